// File: doc/BRIEF.md
# RMII to MII receive converter

This block sits between a reduced-pin Ethernet PHY and a MAC that expects a four-bit MII receive path. It samples the PHY's two-bit receive data, its combined carrier/data-valid line and its receive-error line on a single 50 MHz reference clock. It rebuilds a nibble-wide stream with a separate data-valid and carrier sense, and it generates the MII receive clock from the same reference. Leading idle dibits after carrier comes up are dropped. Nibble alignment is fixed by the first non-zero dibit. When the combined line alternates at the nibble rate, the block reads this as lost carrier while the PHY drains its buffer, so the carrier and data-valid outputs separate.

One parameter selects the line rate. At 100 Mbps a dibit is taken on every reference edge. At 10 Mbps a dibit is taken once every `SLOW_DIV` edges, and the MII clock slows by the same factor. Output data changes only with the rising edge of the generated MII clock, so it is steady when the MAC samples on the falling edge.

Top module: `rmii_to_mii_rx`

## Requirements
- R1: While reset is low, and right after it is released with no traffic, `mii_rxd` is 0000 and `mii_rx_dv`, `mii_rx_er`, `mii_crs` and `mii_col` are 0; reset acts at once, without waiting for a clock edge.
- R2: After the combined carrier/data-valid input rises, dibits of 00 ahead of the first non-zero dibit produce no output nibble. The first non-zero dibit is the first half of the first nibble.
- R3: Two consecutive dibits make one nibble. The earlier dibit goes to `mii_rxd[1:0]` and the later dibit to `mii_rxd[3:2]`; the MAC sees the nibbles in arrival order, each exactly once.
- R4: Whenever `mii_rx_dv` is 0, `mii_rxd` is 0000.
- R5: At 100 Mbps, `mii_rx_clk` toggles on every reference edge, giving a period of two reference cycles. `mii_rxd`, `mii_rx_dv` and `mii_rx_er` change only on the reference edge where `mii_rx_clk` rises.
- R6: From idle, `mii_crs` rises one strobe after the combined input is first seen high. During a frame, a low combined input on the first dibit of a nibble drops `mii_crs`. If the same input is high on the second dibit of that nibble, the nibble is still delivered with `mii_rx_dv` high.
- R7: The combined input low on the second dibit of a nibble ends the frame. The half nibble in progress is discarded, and `mii_rx_dv` falls after the last complete nibble.
- R8: A receive-error input high on either dibit of a nibble raises `mii_rx_er` together with that nibble only; `mii_rx_er` is never 1 while `mii_rx_dv` is 0.
- R9: `mii_col` is always 0.
- R10: With `RATE_SEL`=1, each dibit is sampled once every `SLOW_DIV` (default 10) reference cycles. `mii_rx_clk` then has a period of 2*`SLOW_DIV` cycles and never holds a level for more than `SLOW_DIV` cycles, and nibbles are rebuilt as in R2, R3.
- R11: A carrier event where the combined input falls before any non-zero dibit arrives produces no nibble and leaves `mii_crs` at 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | 50 MHz reference clock, shared with the PHY |
| rst_n | input | 1 | Asynchronous active-low reset |
| rmii_crs_dv | input | 1 | Combined carrier sense / data valid from the PHY |
| rmii_rxd | input | 2 | Receive dibit from the PHY |
| rmii_rx_er | input | 1 | Receive error from the PHY |
| mii_rx_clk | output | 1 | Generated MII receive clock (25 MHz or 2.5 MHz) |
| mii_rxd | output | 4 | Receive nibble toward the MAC |
| mii_rx_dv | output | 1 | Receive data valid toward the MAC |
| mii_rx_er | output | 1 | Receive error, aligned to its nibble |
| mii_crs | output | 1 | Carrier sense recovered from the combined input |
| mii_col | output | 1 | Collision, held at 0 |

## Verification
The assertions check on every cycle that the nibble bus is zero and the error line is low outside data-valid. They also check that the MAC-side outputs move only with a rising MII clock, that every carrier-sense edge follows a matching level on the combined input, and that the generated clock keeps its period. Only the bench's scenarios can show the content-level properties: leading zero dibits are skipped, dibits go into the right half of each nibble, every nibble arrives once and in order, the trailing half nibble is dropped, and a toggled tail is still delivered after carrier sense has dropped.

// File: rtl/rmii_rx_pkg.sv
package rmii_rx_pkg;

   localparam int DIBIT_W = 2;
   localparam int NIB_W   = 2 * DIBIT_W;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_HUNT = 2'd1,
      ST_DATA = 2'd2
   } rx_state_t;

   typedef struct packed {
      logic             valid;
      logic             err;
      logic [NIB_W-1:0] data;
   } nib_t;

   function automatic int strobe_div(input int rate_sel, input int slow_div);
      return (rate_sel == 0) ? 1 : slow_div;
   endfunction

endpackage

// File: rtl/rmii_rx_strobe.sv
module rmii_rx_strobe
   import rmii_rx_pkg::*;
#(
   parameter int RATE_SEL = 0,
   parameter int SLOW_DIV = 10
) (
   input  logic clk,
   input  logic rst_n,
   output logic stb,
   output logic rise,
   output logic mclk
);

   localparam int DIV   = strobe_div(RATE_SEL, SLOW_DIV);
   localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;

   logic clk_q;

   generate
      if (DIV == 1) begin : g_full_rate
         assign stb = 1'b1;
      end else begin : g_divided
         localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (cnt_q == LAST) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         assign stb = (cnt_q == LAST);
      end
   endgenerate

   // MII clock toggles once per strobe; data moves on its rising half
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_q <= 1'b0;
      end else if (stb) begin
         clk_q <= ~clk_q;
      end
   end

   assign rise = stb & ~clk_q;
   assign mclk = clk_q;

endmodule

// File: rtl/rmii_rx_decode.sv
module rmii_rx_decode
   import rmii_rx_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               stb,
   input  logic               crs_dv,
   input  logic [DIBIT_W-1:0] rxd,
   input  logic               rx_er,
   output nib_t               nib,
   output logic               carrier
);

   rx_state_t          state_q;
   logic [DIBIT_W-1:0] low_q;
   logic               err_low_q;
   logic               second_q;
   logic               carrier_q;
   logic               nonzero;

   assign nonzero = (rxd != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         low_q     <= '0;
         err_low_q <= 1'b0;
         second_q  <= 1'b0;
         carrier_q <= 1'b0;
      end else if (stb) begin
         unique case (state_q)
            ST_IDLE: begin
               carrier_q <= crs_dv;
               second_q  <= 1'b0;
               if (crs_dv && nonzero) begin
                  low_q     <= rxd;
                  err_low_q <= rx_er;
                  second_q  <= 1'b1;
                  state_q   <= ST_DATA;
               end else if (crs_dv) begin
                  state_q <= ST_HUNT;
               end
            end
            ST_HUNT: begin
               carrier_q <= crs_dv;
               if (!crs_dv) begin
                  state_q <= ST_IDLE;
               end else if (nonzero) begin
                  low_q     <= rxd;
                  err_low_q <= rx_er;
                  second_q  <= 1'b1;
                  state_q   <= ST_DATA;
               end
            end
            ST_DATA: begin
               if (!second_q) begin
                  // first dibit of a nibble carries carrier state
                  low_q     <= rxd;
                  err_low_q <= rx_er;
                  second_q  <= 1'b1;
                  carrier_q <= carrier_q & crs_dv;
               end else if (crs_dv) begin
                  second_q <= 1'b0;
               end else begin
                  // low on the second dibit: frame over, drop the half nibble
                  second_q  <= 1'b0;
                  carrier_q <= 1'b0;
                  state_q   <= ST_IDLE;
               end
            end
            default: begin
               state_q   <= ST_IDLE;
               carrier_q <= 1'b0;
               second_q  <= 1'b0;
            end
         endcase
      end
   end

   assign nib.valid = stb && (state_q == ST_DATA) && second_q && crs_dv;
   assign nib.err   = err_low_q | rx_er;
   assign nib.data  = {rxd, low_q};
   assign carrier   = carrier_q;

endmodule

// File: rtl/mii_rx_outreg.sv
module mii_rx_outreg
   import rmii_rx_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise,
   input  nib_t             nib_in,
   output logic [NIB_W-1:0] rxd,
   output logic             dv,
   output logic             er
);

   nib_t pend_q;
   nib_t take;

   // a nibble finished on the falling half waits one strobe for the rise
   always_comb take = nib_in.valid ? nib_in : pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         rxd    <= '0;
         dv     <= 1'b0;
         er     <= 1'b0;
      end else if (rise) begin
         dv     <= take.valid;
         rxd    <= take.valid ? take.data : '0;
         er     <= take.valid & take.err;
         pend_q <= '0;
      end else if (nib_in.valid) begin
         pend_q <= nib_in;
      end
   end

endmodule

// File: rtl/rmii_to_mii_rx.sv
module rmii_to_mii_rx
   import rmii_rx_pkg::*;
#(
   parameter int RATE_SEL = 0,
   parameter int SLOW_DIV = 10
) (
   input  logic       ref_clk,
   input  logic       rst_n,
   input  logic       rmii_crs_dv,
   input  logic [1:0] rmii_rxd,
   input  logic       rmii_rx_er,
   output logic       mii_rx_clk,
   output logic [3:0] mii_rxd,
   output logic       mii_rx_dv,
   output logic       mii_rx_er,
   output logic       mii_crs,
   output logic       mii_col
);

   generate
      if (RATE_SEL != 0 && RATE_SEL != 1) begin : g_bad_rate
         $error("RATE_SEL must be 0 (100 Mbps) or 1 (10 Mbps)");
      end
      if (SLOW_DIV < 2) begin : g_bad_div
         $error("SLOW_DIV must be at least 2");
      end
   endgenerate

   logic stb;
   logic rise;
   nib_t nib;

   rmii_rx_strobe #(
      .RATE_SEL (RATE_SEL),
      .SLOW_DIV (SLOW_DIV)
   ) u_strobe (
      .clk   (ref_clk),
      .rst_n (rst_n),
      .stb   (stb),
      .rise  (rise),
      .mclk  (mii_rx_clk)
   );

   rmii_rx_decode u_decode (
      .clk     (ref_clk),
      .rst_n   (rst_n),
      .stb     (stb),
      .crs_dv  (rmii_crs_dv),
      .rxd     (rmii_rxd),
      .rx_er   (rmii_rx_er),
      .nib     (nib),
      .carrier (mii_crs)
   );

   mii_rx_outreg u_out (
      .clk    (ref_clk),
      .rst_n  (rst_n),
      .rise   (rise),
      .nib_in (nib),
      .rxd    (mii_rxd),
      .dv     (mii_rx_dv),
      .er     (mii_rx_er)
   );

   assign mii_col = 1'b0;

endmodule

// File: rtl/rmii_to_mii_rx_chk.sv
module rmii_to_mii_rx_chk #(
   parameter int RATE_SEL = 0,
   parameter int SLOW_DIV = 10
) (
   input logic       clk,
   input logic       rst_n,
   input logic       crs_dv,
   input logic       mclk,
   input logic [3:0] rxd,
   input logic       dv,
   input logic       er,
   input logic       crs
);

   logic armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed_q <= 1'b0;
      else        armed_q <= 1'b1;
   end

   AST_RXD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !dv |-> (rxd == 4'b0000)); // R4

   AST_ER_NEEDS_DV: assert property (@(posedge clk) disable iff (!rst_n)
      er |-> dv); // R8

   AST_OUT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && !$rose(mclk)) |-> ($stable(rxd) && $stable(dv) && $stable(er))); // R5

   AST_CRS_RISE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && $rose(crs)) |-> $past(crs_dv)); // R6

   AST_CRS_FALL_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && $fell(crs)) |-> !$past(crs_dv)); // R6

   generate
      if (RATE_SEL == 0) begin : g_fast
         AST_CLK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
            armed_q |-> (mclk != $past(mclk))); // R5
      end else begin : g_slow
         logic mclk_d;
         int   gap_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               mclk_d <= 1'b0;
               gap_q  <= 0;
            end else begin
               mclk_d <= mclk;
               gap_q  <= (mclk != mclk_d) ? 0 : gap_q + 1;
            end
         end
         AST_SLOW_LEVEL_MAX: assert property (@(posedge clk) disable iff (!rst_n)
            gap_q <= SLOW_DIV); // R10
      end
   endgenerate

endmodule

bind rmii_to_mii_rx rmii_to_mii_rx_chk #(
   .RATE_SEL (RATE_SEL),
   .SLOW_DIV (SLOW_DIV)
) u_chk (
   .clk    (ref_clk),
   .rst_n  (rst_n),
   .crs_dv (rmii_crs_dv),
   .mclk   (mii_rx_clk),
   .rxd    (mii_rxd),
   .dv     (mii_rx_dv),
   .er     (mii_rx_er),
   .crs    (mii_crs)
);

// File: tb/tb_rmii_to_mii_rx.sv
module tb_rmii_to_mii_rx;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   // 100 Mbps instance
   logic       a_crs_dv = 1'b0;
   logic [1:0] a_rxd = 2'b00;
   logic       a_er = 1'b0;
   logic       a_mclk, a_dv, a_er_o, a_crs, a_col;
   logic [3:0] a_rxd_o;

   // 10 Mbps instance
   logic       b_crs_dv = 1'b0;
   logic [1:0] b_rxd = 2'b00;
   logic       b_er = 1'b0;
   logic       b_mclk, b_dv, b_er_o, b_crs, b_col;
   logic [3:0] b_rxd_o;

   rmii_to_mii_rx #(.RATE_SEL(0)) dut (
      .ref_clk(clk), .rst_n(rst_n), .rmii_crs_dv(a_crs_dv), .rmii_rxd(a_rxd),
      .rmii_rx_er(a_er), .mii_rx_clk(a_mclk), .mii_rxd(a_rxd_o), .mii_rx_dv(a_dv),
      .mii_rx_er(a_er_o), .mii_crs(a_crs), .mii_col(a_col));

   rmii_to_mii_rx #(.RATE_SEL(1), .SLOW_DIV(10)) dut10 (
      .ref_clk(clk), .rst_n(rst_n), .rmii_crs_dv(b_crs_dv), .rmii_rxd(b_rxd),
      .rmii_rx_er(b_er), .mii_rx_clk(b_mclk), .mii_rxd(b_rxd_o), .mii_rx_dv(b_dv),
      .mii_rx_er(b_er_o), .mii_crs(b_crs), .mii_col(b_col));

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 1'b0;

   // {lead 00 dibits, error nibble index (F = none), tail mode, nibbles n7..n0}
   // tail mode: 0 plain end, 1 last two nibbles toggled, 2 stray half nibble
   localparam logic [41:0] VEC [6] = '{
      {4'd0, 4'hF, 2'd0, 32'h4321D555},
      {4'd3, 4'hF, 2'd0, 32'hFECBAD55},
      {4'd5, 4'd4, 2'd0, 32'h8765D555},
      {4'd1, 4'hF, 2'd1, 32'h9A0FD555},
      {4'd2, 4'd6, 2'd2, 32'h3C21D555},
      {4'd0, 4'hF, 2'd0, 32'h00007D5E}
   };

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   // ---- monitor, fast instance ----
   logic       a_prev_mclk = 1'b0;
   logic [3:0] a_prev_rxd = '0;
   logic       a_prev_dv = 1'b0, a_prev_er = 1'b0;
   logic [3:0] cap_n [32];
   logic       cap_e [32];
   int cap_cnt = 0;
   int r4_viol = 0, r8_viol = 0, col_viol = 0, r5_bad = 0;
   int a_last_rise = -1;
   bit saw_split = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (a_mclk && !a_prev_mclk) begin
            if (a_last_rise >= 0 && (cyc - a_last_rise) != 2) r5_bad++;
            a_last_rise = cyc;
            if (a_dv && cap_cnt < 32) begin
               cap_n[cap_cnt] = a_rxd_o;
               cap_e[cap_cnt] = a_er_o;
               cap_cnt++;
            end
         end else if (a_rxd_o != a_prev_rxd || a_dv != a_prev_dv || a_er_o != a_prev_er) begin
            r5_bad++;
         end
         if (!a_dv && a_rxd_o != 4'd0) r4_viol++;
         if (!a_dv && a_er_o) r8_viol++;
         if (a_col || b_col) col_viol++;
         if (a_dv && !a_crs) saw_split = 1'b1;
      end
      a_prev_mclk = a_mclk;
      a_prev_rxd  = a_rxd_o;
      a_prev_dv   = a_dv;
      a_prev_er   = a_er_o;
   end

   // ---- monitor, slow instance ----
   logic       b_prev_mclk = 1'b0;
   logic [3:0] capb_n [8];
   int capb_cnt = 0;
   int b_last_rise = -1;
   int r10_bad = 0;
   int b_rises = 0;

   always @(negedge clk) begin
      if (rst_n && b_mclk && !b_prev_mclk) begin
         if (b_last_rise >= 0 && (cyc - b_last_rise) != 20) r10_bad++;
         b_last_rise = cyc;
         b_rises++;
         if (b_dv && capb_cnt < 8) begin
            capb_n[capb_cnt] = b_rxd_o;
            capb_cnt++;
         end
      end
      b_prev_mclk = b_mclk;
   end

   // ---- watchdog ----
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 60000 && !done) begin
         errors++;
         $display("FAIL watchdog (all requirements): actual %0d cycles expected below %0d", cyc, 60000);
         summary();
         $finish;
      end
   end

   task automatic put_a(input logic crs, input logic [1:0] d, input logic e);
      a_crs_dv = crs;
      a_rxd    = d;
      a_er     = e;
      @(negedge clk);
   endtask

   task automatic put_b(input logic crs, input logic [1:0] d);
      b_crs_dv = crs;
      b_rxd    = d;
      repeat (10) @(negedge clk);
   endtask

   task automatic run_vector(input int idx);
      logic [41:0] v;
      int lead, eidx, mode;
      logic [31:0] nibs;
      bit first;
      v    = VEC[idx];
      lead = int'(v[41:38]);
      eidx = int'(v[37:34]);
      mode = int'(v[33:32]);
      nibs = v[31:0];
      cap_cnt   = 0;
      saw_split = 1'b0;
      first     = 1'b1;
      check(a_crs == 1'b0, "R6", $sformatf("vec%0d crs before frame", idx), a_crs, 0);
      for (int k = 0; k < lead; k++) begin
         put_a(1'b1, 2'b00, 1'b0);
         if (first) begin
            check(a_crs == 1'b1, "R6", $sformatf("vec%0d crs one strobe after rise", idx), a_crs, 1);
            first = 1'b0;
         end
      end
      for (int n = 0; n < 8; n++) begin
         put_a((mode == 1 && n >= 6) ? 1'b0 : 1'b1, nibs[4*n +: 2], 1'b0);
         if (first) begin
            check(a_crs == 1'b1, "R6", $sformatf("vec%0d crs one strobe after rise", idx), a_crs, 1);
            first = 1'b0;
         end
         put_a(1'b1, nibs[4*n+2 +: 2], (n == eidx));
      end
      if (mode == 2) begin
         put_a(1'b1, 2'b01, 1'b0);
         put_a(1'b0, 2'b01, 1'b0);
      end
      repeat (10) put_a(1'b0, 2'b00, 1'b0);
      // R2 R7: exactly the eight full nibbles, leading zeros and stray half dropped
      check(cap_cnt == 8, "R2/R7", $sformatf("vec%0d nibble count", idx), cap_cnt, 8);
      for (int n = 0; n < 8; n++) begin
         if (n < cap_cnt) begin
            check(cap_n[n] == nibs[4*n +: 4], "R3", $sformatf("vec%0d nibble %0d", idx, n),
                  cap_n[n], nibs[4*n +: 4]);
            check(cap_e[n] == (n == eidx), "R8", $sformatf("vec%0d error flag %0d", idx, n),
                  cap_e[n], (n == eidx));
         end
      end
      if (mode == 1) begin
         check(saw_split, "R6", $sformatf("vec%0d data valid held after carrier drop", idx),
               saw_split, 1);
      end
      check(a_crs == 1'b0 && a_dv == 1'b0, "R7",
            $sformatf("vec%0d idle after frame (crs,dv)", idx), {a_crs, a_dv}, 0);
   endtask

   initial begin
      @(negedge clk);
      // R1: outputs quiet in reset
      check(a_dv == 0 && a_rxd_o == 0 && a_er_o == 0 && a_crs == 0 && a_col == 0,
            "R1", "outputs during reset", {a_dv, a_er_o, a_crs, a_col, a_rxd_o}, 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (6) @(negedge clk);
      check(a_dv == 0 && a_rxd_o == 0 && a_crs == 0, "R1", "outputs after reset",
            {a_dv, a_crs, a_rxd_o}, 0);
      check(a_last_rise >= 0, "R5", "MII clock running after reset", a_last_rise >= 0, 1);

      for (int i = 0; i < 6; i++) run_vector(i);

      // R11: false carrier, only zero dibits
      cap_cnt = 0;
      repeat (6) put_a(1'b1, 2'b00, 1'b0);
      repeat (8) put_a(1'b0, 2'b00, 1'b0);
      check(cap_cnt == 0, "R11", "false carrier nibbles", cap_cnt, 0);
      check(a_crs == 1'b0, "R11", "crs after false carrier", a_crs, 0);

      // R1: asynchronous reset in mid-frame
      put_a(1'b1, 2'b01, 1'b0);
      repeat (9) put_a(1'b1, 2'b01, 1'b1);
      #1 rst_n = 1'b0;
      #1 check(a_dv == 0 && a_rxd_o == 0 && a_er_o == 0 && a_crs == 0,
               "R1", "mid-frame reset outputs", {a_dv, a_er_o, a_crs, a_rxd_o}, 0);
      a_crs_dv = 1'b0; a_rxd = 2'b00; a_er = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      b_last_rise = -1;
      a_last_rise = -1;
      repeat (4) @(negedge clk);

      // R10: slow rate, dibits held ten reference cycles
      capb_cnt = 0;
      repeat (2) put_b(1'b1, 2'b00);
      put_b(1'b1, 2'b01); put_b(1'b1, 2'b01);   // 5
      put_b(1'b1, 2'b01); put_b(1'b1, 2'b11);   // D
      put_b(1'b1, 2'b10); put_b(1'b1, 2'b01);   // 6
      put_b(1'b1, 2'b01); put_b(1'b1, 2'b10);   // 9
      repeat (4) put_b(1'b0, 2'b00);
      check(capb_cnt == 4, "R10", "slow nibble count", capb_cnt, 4);
      check(capb_n[0] == 4'h5, "R10", "slow nibble 0", capb_n[0], 5);
      check(capb_n[1] == 4'hD, "R10", "slow nibble 1", capb_n[1], 13);
      check(capb_n[2] == 4'h6, "R10", "slow nibble 2", capb_n[2], 6);
      check(capb_n[3] == 4'h9, "R10", "slow nibble 3", capb_n[3], 9);
      check(r10_bad == 0 && b_rises > 4, "R10", "slow clock period faults", r10_bad, 0);

      // running tallies from the monitors
      check(r4_viol == 0, "R4", "nonzero data while not valid", r4_viol, 0);
      check(r8_viol == 0, "R8", "error while not valid", r8_viol, 0);
      check(col_viol == 0, "R9", "collision seen high", col_viol, 0);
      check(r5_bad == 0, "R5", "clock period or off-edge output changes", r5_bad, 0);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule